// File: doc/BRIEF.md
# Dual-Mode Pixel Strobe Generator

This block derives a pixel strobe from a 101 MHz system clock by integer division. It has two graphics modes, and the mode can be changed while the block is running. The slow mode divides by four, which gives about 25 MHz. The fast mode divides by three, which gives about 33.7 MHz. In both modes the strobe is high for exactly one system clock per pixel period, so the duty cycle is asymmetric: 25 % high in the slow mode and about 33 % high in the fast mode.

A 16-bit colour word arrives in 5-6-5 packing. The word is captured on the falling edge of the strobe and reduced to a 12-bit 4:4:4 pixel. Both modes keep only the upper four bits of each channel, so the output width does not change when the mode changes. A new mode value is accepted only when the current pixel period ends. This means a mode change never cuts a pulse short and never produces a runt.

Top module: `pixstrobe_dual`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `pix_clk` is 0, `pix_rgb` is 0 and the slow mode is active. The first `pix_clk` pulse after reset comes on the third rising `sysclk` edge after `rst_n` is sampled high.
- R2: With `mode_fast` = 0, `pix_clk` repeats every 4 `sysclk` cycles.
- R3: With `mode_fast` = 1, `pix_clk` repeats every 3 `sysclk` cycles.
- R4: Every `pix_clk` high pulse lasts exactly one `sysclk` cycle.
- R5: A change on `mode_fast` takes effect only when the running period ends. If the input changes during a slow period, that period still lasts 4 cycles, and the following periods use the new length.
- R6: On the `sysclk` edge where `pix_clk` falls, `pix_rgb` loads the packed `vid_in` value. The packing is: `pix_rgb[11:8]` = `vid_in[4:1]` (red), `pix_rgb[7:4]` = `vid_in[10:7]` (green), `pix_rgb[3:0]` = `vid_in[15:12]` (blue).
- R7: `vid_in` bits 11, 6, 5 and 0 have no effect on `pix_rgb` in either mode.
- R8: `pix_rgb` holds its value on every other edge, whatever happens on `vid_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sysclk | input | 1 | System clock, nominally 101 MHz |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_fast | input | 1 | 0 = divide by 4, 1 = divide by 3 |
| vid_in | input | 16 | Colour word: blue 15:11, green 10:5, red 4:0 |
| pix_clk | output | 1 | Pixel strobe, high for one sysclk per period |
| pix_rgb | output | 12 | Captured pixel: red 11:8, green 7:4, blue 3:0 |

## Verification
If the phase counter is corrupted, the spacing between `pix_clk` pulses is wrong, and this shows within one pixel period (at most four cycles). If the mode latch is wrong, it shows as a wrong pulse spacing either in the period where the mode changes or in the period after it. If the capture strobe or the channel slicing is wrong, `pix_rgb` either changes on the wrong edge or holds the wrong bit fields. This is visible one cycle after the pulse falls.

// File: rtl/pixstrobe_pkg.sv
// Package: pixstrobe_pkg
// Holds the shared constants and types of the pixel strobe generator.
// Assumes that both divide ratios are at least 2, so that a period always
// has at least one low cycle.
package pixstrobe_pkg;
    localparam int DIV_SLOW  = 4;
    localparam int DIV_FAST  = 3;
    localparam int PH_W      = $clog2(DIV_SLOW);
    localparam int VID_W     = 16;
    localparam int CH_BITS   = 4;
    localparam int N_CH      = 3;
    localparam int PIX_W     = CH_BITS * N_CH;

    typedef enum logic {MODE_SLOW = 1'b0, MODE_FAST = 1'b1} pix_mode_e;

    // Returns the top bit of each input channel: 0 = red, 1 = green, 2 = blue.
    function automatic int chan_msb(input int ch);
        case (ch)
            0:       chan_msb = 4;
            1:       chan_msb = 10;
            default: chan_msb = 15;
        endcase
    endfunction
endpackage

// File: rtl/pixstrobe_phase.sv
// Module: pixstrobe_phase
// Phase counter and mode latch. The counter runs from 0 up to the last
// phase of the active mode and then wraps. The requested mode is copied
// into the active mode only on a wrap, so a period never changes length
// while it is running. Assumes mode_req is synchronous to clk.
module pixstrobe_phase
    import pixstrobe_pkg::*;
#(
    parameter int DIV_LO = DIV_SLOW,
    parameter int DIV_HI = DIV_FAST,
    localparam int W     = $clog2(DIV_LO)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_req,
    output logic [W-1:0]  phase,
    output logic          wrap_next,
    output pix_mode_e     mode_act
);
    localparam logic [W-1:0] LAST_LO = W'(DIV_LO - 1);
    localparam logic [W-1:0] LAST_HI = W'(DIV_HI - 1);

    logic [W-1:0] last_ph;

    // Select the last phase value for the active mode.
    always_comb begin
        last_ph   = (mode_act == MODE_FAST) ? LAST_HI : LAST_LO;
        wrap_next = (phase == last_ph);
    end

    // Advance the phase, wrap at the end of the period and latch the mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= W'(1);
            mode_act <= MODE_SLOW;
        end else if (wrap_next) begin
            phase    <= '0;
            mode_act <= pix_mode_e'(mode_req);
        end else begin
            phase    <= phase + W'(1);
        end
    end

    // The mode only changes on a cycle that followed a wrap.
    assert_mode_at_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap_next |=> $stable(mode_act));

    // The phase never runs past the last phase of the active mode.
    assert_phase_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_act == MODE_FAST) |-> (phase <= LAST_HI));
endmodule

// File: rtl/pixstrobe_pulse.sv
// Module: pixstrobe_pulse
// Registers the pixel strobe. The strobe is high for the one cycle in
// which the phase is 0. Assumes that the phase counter wraps to 0.
module pixstrobe_pulse #(
    parameter int W = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wrap_next,
    output logic  strobe
);
    // The strobe goes high on the edge where the phase wraps to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe <= 1'b0;
        else        strobe <= wrap_next;
    end

    // Every high pulse lasts exactly one cycle.
    assert_single_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);
endmodule

// File: rtl/pixstrobe_pack.sv
// Module: pixstrobe_pack
// Captures the 5-6-5 word and keeps the upper four bits of each channel.
// Loads only on the edge where the strobe falls. Assumes that the strobe
// is high for a single cycle.
module pixstrobe_pack
    import pixstrobe_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               strobe,
    input  logic [VID_W-1:0]   vid,
    output logic [PIX_W-1:0]   rgb
);
    logic [PIX_W-1:0] packed_w;

    // Slice the top bits of each channel. Red goes at the top of the output.
    for (genvar ch = 0; ch < N_CH; ch++) begin : g_chan
        localparam int MSB = chan_msb(ch);
        assign packed_w[(N_CH-1-ch)*CH_BITS +: CH_BITS] = vid[MSB -: CH_BITS];
    end

    // Capture the packed pixel as the strobe falls.
    always_ff @(posedge clk) begin
        if (!rst_n)      rgb <= '0;
        else if (strobe) rgb <= packed_w;
    end

    // The pixel is held on every edge outside a falling strobe.
    assert_hold_pixel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(rgb));
endmodule

// File: rtl/pixstrobe_dual.sv
// Module: pixstrobe_dual
// Top level of the dual-mode pixel strobe generator. It divides sysclk by
// 4 or by 3 and captures a 12-bit pixel on the falling strobe. Assumes
// that mode_fast and vid_in are synchronous to sysclk.
module pixstrobe_dual
    import pixstrobe_pkg::*;
(
    input  logic              sysclk,
    input  logic              rst_n,
    input  logic              mode_fast,
    input  logic [15:0]       vid_in,
    output logic              pix_clk,
    output logic [11:0]       pix_rgb
);
    logic [PH_W-1:0] phase;
    logic            wrap_next;
    pix_mode_e       mode_act;

    pixstrobe_phase #(.DIV_LO(DIV_SLOW), .DIV_HI(DIV_FAST)) phase_i (
        .clk       (sysclk),
        .rst_n     (rst_n),
        .mode_req  (mode_fast),
        .phase     (phase),
        .wrap_next (wrap_next),
        .mode_act  (mode_act)
    );

    pixstrobe_pulse #(.W(PH_W)) pulse_i (
        .clk       (sysclk),
        .rst_n     (rst_n),
        .wrap_next (wrap_next),
        .strobe    (pix_clk)
    );

    pixstrobe_pack pack_i (
        .clk    (sysclk),
        .rst_n  (rst_n),
        .strobe (pix_clk),
        .vid    (vid_in),
        .rgb    (pix_rgb)
    );

    logic [2:0] low_run;
    pix_mode_e  low_mode;

    // Count the low cycles before each pulse and note the mode they ran in.
    always_ff @(posedge sysclk) begin
        if (!rst_n) begin
            low_run  <= '0;
            low_mode <= MODE_SLOW;
        end else if (pix_clk) begin
            low_run  <= '0;
        end else begin
            low_run  <= low_run + 3'd1;
            low_mode <= mode_act;
        end
    end

    // In the slow mode each pulse comes after three low cycles.
    assert_slow_period_R2: assert property (@(posedge sysclk) disable iff (!rst_n)
        (pix_clk && low_mode == MODE_SLOW) |-> (low_run == 3'(DIV_SLOW - 1)));

    // In the fast mode each pulse comes after two low cycles.
    assert_fast_period_R3: assert property (@(posedge sysclk) disable iff (!rst_n)
        (pix_clk && low_mode == MODE_FAST) |-> (low_run == 3'(DIV_FAST - 1)));
endmodule

// File: tb/pixstrobe_dual_tb.sv
// Directed bench for pixstrobe_dual. Each task checks its own results.
// Inputs are driven and outputs sampled at the falling edge of sysclk.
module pixstrobe_dual_tb_top;
    logic        sysclk = 1'b0;
    logic        rst_n  = 1'b0;
    logic        mode_fast = 1'b0;
    logic [15:0] vid_in = '0;
    logic        pix_clk;
    logic [11:0] pix_rgb;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    pixstrobe_dual dut_i (
        .sysclk    (sysclk),
        .rst_n     (rst_n),
        .mode_fast (mode_fast),
        .vid_in    (vid_in),
        .pix_clk   (pix_clk),
        .pix_rgb   (pix_rgb)
    );

    always #4 sysclk = ~sysclk;

    // Watchdog: a run that hangs counts as a failure.
    always @(posedge sysclk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected < 100000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    function automatic logic [11:0] pack(input logic [15:0] v);
        return {v[4:1], v[10:7], v[15:12]};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_high();
        @(negedge sysclk);
        while (!pix_clk) @(negedge sysclk);
    endtask

    // Return the number of cycles until the next high, starting from a high.
    task automatic gap(output int g);
        g = 0;
        do begin
            @(negedge sysclk);
            g++;
        end while (!pix_clk && g < 20);
    endtask

    task automatic t_reset();
        int g;
        rst_n = 1'b0;
        repeat (3) @(negedge sysclk);
        check("R1 clk in reset", pix_clk, 0);
        check("R1 rgb in reset", pix_rgb, 0);
        rst_n = 1'b1;
        @(negedge sysclk);
        check("R1 clk after reset", pix_clk, 0);
        @(negedge sysclk);
        check("R1 clk 2nd", pix_clk, 0);
        @(negedge sysclk);
        check("R1 first pulse", pix_clk, 1);
        gap(g);
        check("R1 slow after reset", g, 4);
    endtask

    task automatic t_period(input logic m, input int exp, input string req);
        int g;
        mode_fast = m;
        wait_high();
        gap(g);                         // may span a mode change
        for (int i = 0; i < 3; i++) begin
            @(negedge sysclk);
            check({req, " high width"}, pix_clk, 0);   // R4
            while (!pix_clk) @(negedge sysclk);
        end
        for (int i = 0; i < 3; i++) begin
            gap(g);
            check(req, g, exp);
        end
    endtask

    task automatic t_switch(input logic to_fast);
        int g;
        mode_fast = ~to_fast;
        wait_high(); wait_high(); wait_high();
        @(negedge sysclk);
        mode_fast = to_fast;            // mid-period change
        g = 1;
        while (!pix_clk) begin @(negedge sysclk); g++; end
        check("R5 running period kept", g, to_fast ? 4 : 3);
        gap(g);
        check("R5 new period", g, to_fast ? 3 : 4);
    endtask

    task automatic t_capture(input logic m, input logic [15:0] v);
        logic [11:0] exp;
        mode_fast = m;
        wait_high(); wait_high();
        vid_in = v;
        exp = pack(v);
        @(negedge sysclk);
        check("R6 capture", pix_rgb, exp);
        vid_in = ~v;
        for (int i = 0; i < 2; i++) begin
            @(negedge sysclk);
            check("R8 hold", pix_rgb, exp);
        end
    endtask

    task automatic t_ignored(input logic m);
        logic [15:0] base;
        base = 16'h5A3C;
        t_capture(m, base);
        t_capture(m, base ^ 16'h0861);    // flip bits 11, 6, 5, 0
        check("R7 ignored bits", pix_rgb, pack(base));
        check("R7 fields", pack(base ^ 16'h0861), pack(base));
    endtask

    initial begin
        t_reset();
        t_period(1'b0, 4, "R2");
        t_period(1'b1, 3, "R3");
        t_switch(1'b1);
        t_switch(1'b0);
        t_capture(1'b0, 16'hF00F);
        t_capture(1'b1, 16'h07E0);
        t_capture(1'b1, 16'hA5C3);
        t_ignored(1'b0);
        t_ignored(1'b1);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule